// File: doc/BRIEF.md
# Timed Event Scheduler with Cancel

This block schedules typed events against a free-running 64-bit tick count. A client asks for an event either at an absolute tick value or at an offset from the present count. When the count is advanced, each event whose due time has been reached is announced as a one-cycle pulse on the output bit for its type, earliest first. A client may also withdraw a pending event by naming its type. The block then returns how many ticks that event still had to wait, so the caller can charge those ticks as a stall.

The block holds one pending slot per event type. A slot is filled by an enqueue and emptied by a firing or a cancel. Type code 4 is a sentinel that is armed out of reset at the largest 64-bit time. If it ever fires, a sticky fatal flag is raised. Each firing also drives the side-effect strobes that belong to its type: interrupt requests and busy-flag clears for the serial DMA, parallel DMA and bus-write paths.

The request channel is valid/ready. A request transfers on a rising clock edge where both `req_valid` and `req_ready` are high, and at most one request transfers per clock. `req_ready` is low while reset is asserted and for the first clock after reset is released. It is high from then on, so the only back-pressure is at start-up. The cancel response has no ready signal: the caller must capture `rsp_valid`/`rsp_remain` in the cycle they appear.

Top module: `event_timer_sched`

## Requirements
- R1: After reset, `now_o` is 0, `fire_o` is 0, `fatal_o` is 0 and `rsp_valid` is 0. `req_ready` is 0 during reset and is 1 from the second clock edge after reset is released.
- R2: On a clock edge with `adv_valid` high, `now_o` increases by `adv_amount`. With `adv_valid` low, `now_o` holds.
- R3: An accepted request with `req_op`=0 (absolute enqueue) sets the type's due time to `req_time`. The type's `fire_o` bit pulses for one cycle, in the cycle after `now_o` first shows a value at or above the due time.
- R4: An accepted request with `req_op`=1 (relative enqueue) sets the due time to `req_time` plus the `now_o` value of the accepting cycle. Firing then follows R3.
- R5: When several events are due, they fire on successive cycles in ascending due-time order, with ties going to the lower type code. At most one `fire_o` bit is high in any cycle.
- R6: Enqueuing a type that is already pending replaces its due time. The event fires once, at the new time only.
- R7: An accepted request with `req_op`=2 (cancel) produces, on the next cycle, `rsp_valid`=1 and `rsp_remain` = due time minus the `now_o` value of the accepting cycle. This subtraction ignores any advance on that same edge. The event is removed and never fires.
- R8: Cancelling a type that has nothing pending, or type 0 (none), or a code of 5 or more, returns `rsp_valid`=1 with `rsp_remain`=0.
- R9: A cancel accepted on the same edge at which its type would fire wins: no pulse is produced. `rsp_remain` is 0 because the due time is not above the current count.
- R10: Type codes are 1 = bus-write done, 2 = parallel DMA done, 3 = serial DMA, 4 = sentinel. In the same cycle as the pulse:
  - a type 1 firing pulses only `io_busy_clr`;
  - a type 2 firing pulses `par_irq` and `par_dma_busy_clr`;
  - a type 3 firing pulses `serial_irq` and `serial_busy_clr`.
- R11: The sentinel (type 4) is pending from reset with due time 2^64-1. When it fires, `fatal_o` goes high in the same cycle and stays high until reset.
- R12: An enqueue with type 0 or a type code of 5 or more is ignored, and so is any request with `req_op`=3. None of these produces a firing or a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Advance the tick count this clock |
| adv_amount | input | 64 | Ticks to add when advancing |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 absolute enqueue, 1 relative enqueue, 2 cancel, 3 reserved |
| req_type | input | 3 | Event type code |
| req_time | input | 64 | Due time or offset for enqueues |
| rsp_valid | output | 1 | Cancel response present (one cycle) |
| rsp_remain | output | 64 | Ticks the cancelled event still had |
| now_o | output | 64 | Current tick count |
| fire_o | output | 5 | One-cycle firing pulse, one bit per type code |
| io_busy_clr | output | 1 | Bus-write done: clear I/O busy |
| par_irq | output | 1 | Parallel DMA interrupt request |
| par_dma_busy_clr | output | 1 | Clear parallel DMA busy |
| serial_irq | output | 1 | Serial DMA interrupt request |
| serial_busy_clr | output | 1 | Clear serial busy |
| fatal_o | output | 1 | Sticky: sentinel fired |

## Verification
The bench steps the count to exactly one tick below a due time and then onto it. A comparator that is off by one, or a firing that lands a cycle early or late, shows up as a pulse at the wrong point. Two events are given the same due time to check the tie rule: a wrong tie break, or firing several at once, gives a misordered log or overlapping pulses. A cancel is timed onto the edge where its event falls due, and another arrives together with an advance. A design that lets the firing win, or subtracts the updated count, returns a stray pulse or a remaining time that is 10 too small. The sentinel is both cancelled and re-armed. A wrong preload gives a wrong remaining time, and a fatal flag that is not sticky drops after the pulse.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
  // Event type codes: drive fire_o bit positions and side-effect decode
  localparam int EVT_NONE  = 0;
  localparam int EVT_BUSWR = 1;
  localparam int EVT_PDMA  = 2;
  localparam int EVT_SDMA  = 3;
  localparam int EVT_SENT  = 4;

  typedef enum logic [1:0] {
    OP_ENQ_ABS = 2'd0,
    OP_ENQ_REL = 2'd1,
    OP_CANCEL  = 2'd2,
    OP_RSVD    = 2'd3
  } req_op_e;
endpackage

// File: rtl/evsched_slots.sv
module evsched_slots #(
  parameter int TIME_W  = 64,
  parameter int NUM_EVT = 5,
  parameter int TYPE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_set,
  input  logic [TYPE_W-1:0] wr_type,
  input  logic [TIME_W-1:0] wr_due,
  input  logic              fire_en,
  input  logic [TYPE_W-1:0] fire_type,
  output logic [NUM_EVT-1:0] pend_o,
  output logic [TIME_W-1:0]  due_o [NUM_EVT]
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_slot
    if (i == 0) begin : g_none
      assign pend_o[i] = 1'b0;
      assign due_o[i]  = '0;
    end else begin : g_live
      localparam logic              RST_PEND = (i == NUM_EVT - 1);
      localparam logic [TIME_W-1:0] RST_DUE  = (i == NUM_EVT - 1) ? {TIME_W{1'b1}} : '0;
      logic              pend_q;
      logic [TIME_W-1:0] due_q;
      logic              hit_wr, hit_fire;

      assign hit_wr   = wr_en   && (wr_type   == TYPE_W'(i));
      assign hit_fire = fire_en && (fire_type == TYPE_W'(i));

      // a request to this slot takes precedence over its own firing
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= RST_PEND;
          due_q  <= RST_DUE;
        end else if (hit_wr) begin
          pend_q <= wr_set;
          if (wr_set) due_q <= wr_due;
        end else if (hit_fire) begin
          pend_q <= 1'b0;
        end
      end

      assign pend_o[i] = pend_q;
      assign due_o[i]  = due_q;
    end
  end
endmodule

// File: rtl/evsched_pick.sv
module evsched_pick #(
  parameter int TIME_W  = 64,
  parameter int NUM_EVT = 5,
  parameter int TYPE_W  = 3
) (
  input  logic [NUM_EVT-1:0] pend,
  input  logic [TIME_W-1:0]  due [NUM_EVT],
  input  logic [TIME_W-1:0]  now,
  input  logic [NUM_EVT-1:0] block,
  output logic               hit,
  output logic [TYPE_W-1:0]  sel
);
  logic [TIME_W-1:0] best;

  // strict less-than keeps the lower type code on equal due times
  always_comb begin
    hit  = 1'b0;
    sel  = '0;
    best = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (pend[i] && !block[i] && (due[i] <= now) && (!hit || (due[i] < best))) begin
        hit  = 1'b1;
        sel  = TYPE_W'(i);
        best = due[i];
      end
    end
  end
endmodule

// File: rtl/evsched_fx.sv
module evsched_fx (
  input  logic fire_buswr,
  input  logic fire_pdma,
  input  logic fire_sdma,
  output logic io_busy_clr,
  output logic par_irq,
  output logic par_dma_busy_clr,
  output logic serial_irq,
  output logic serial_busy_clr
);
  assign io_busy_clr      = fire_buswr;
  assign par_irq          = fire_pdma;
  assign par_dma_busy_clr = fire_pdma;
  assign serial_irq       = fire_sdma;
  assign serial_busy_clr  = fire_sdma;
endmodule

// File: rtl/event_timer_sched.sv
module event_timer_sched
  import evsched_pkg::*;
#(
  parameter  int TIME_W  = 64,
  parameter  int NUM_EVT = 5,
  localparam int TYPE_W  = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_valid,
  input  logic [TIME_W-1:0]  adv_amount,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [TYPE_W-1:0]  req_type,
  input  logic [TIME_W-1:0]  req_time,
  output logic               rsp_valid,
  output logic [TIME_W-1:0]  rsp_remain,
  output logic [TIME_W-1:0]  now_o,
  output logic [NUM_EVT-1:0] fire_o,
  output logic               io_busy_clr,
  output logic               par_irq,
  output logic               par_dma_busy_clr,
  output logic               serial_irq,
  output logic               serial_busy_clr,
  output logic               fatal_o
);
  localparam int SENT = NUM_EVT - 1;
  localparam logic [TYPE_W-1:0] TYPE_LIMIT = TYPE_W'(NUM_EVT);

  logic [TIME_W-1:0]  now_q, new_due, remain_c, rsp_remain_q;
  logic [NUM_EVT-1:0] pend, block_mask, fire_q;
  logic [TIME_W-1:0]  due [NUM_EVT];
  logic               accept, is_enq, is_cancel, type_ok, wr_en;
  logic               hit, fatal_q, rsp_valid_q, ready_q;
  logic [TYPE_W-1:0]  ty_idx, sel_type;

  // request decode
  always_comb begin
    accept    = req_valid && ready_q;
    is_enq    = (req_op == OP_ENQ_ABS) || (req_op == OP_ENQ_REL);
    is_cancel = (req_op == OP_CANCEL);
    type_ok   = (req_type != '0) && (req_type < TYPE_LIMIT);
    wr_en     = accept && type_ok && (is_enq || is_cancel);
    ty_idx    = type_ok ? req_type : '0;
    new_due   = (req_op == OP_ENQ_REL) ? (req_time + now_q) : req_time;
    block_mask = wr_en ? (NUM_EVT'(1) << ty_idx) : '0;
    remain_c  = '0;
    if (type_ok && pend[ty_idx] && (due[ty_idx] > now_q))
      remain_c = due[ty_idx] - now_q;
  end

  evsched_slots #(.TIME_W(TIME_W), .NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_set    (is_enq),
    .wr_type   (ty_idx),
    .wr_due    (new_due),
    .fire_en   (hit),
    .fire_type (sel_type),
    .pend_o    (pend),
    .due_o     (due)
  );

  evsched_pick #(.TIME_W(TIME_W), .NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W)) u_pick (
    .pend  (pend),
    .due   (due),
    .now   (now_q),
    .block (block_mask),
    .hit   (hit),
    .sel   (sel_type)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q        <= '0;
      fire_q       <= '0;
      fatal_q      <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_remain_q <= '0;
      ready_q      <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (adv_valid) now_q <= now_q + adv_amount;
      fire_q <= hit ? (NUM_EVT'(1) << sel_type) : '0;
      if (hit && (sel_type == TYPE_W'(SENT))) fatal_q <= 1'b1;
      rsp_valid_q <= accept && is_cancel;
      if (accept && is_cancel) rsp_remain_q <= remain_c;
    end
  end

  evsched_fx u_fx (
    .fire_buswr       (fire_q[EVT_BUSWR]),
    .fire_pdma        (fire_q[EVT_PDMA]),
    .fire_sdma        (fire_q[EVT_SDMA]),
    .io_busy_clr      (io_busy_clr),
    .par_irq          (par_irq),
    .par_dma_busy_clr (par_dma_busy_clr),
    .serial_irq       (serial_irq),
    .serial_busy_clr  (serial_busy_clr)
  );

  assign req_ready  = ready_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_remain = rsp_remain_q;
  assign now_o      = now_q;
  assign fire_o     = fire_q;
  assign fatal_o    = fatal_q;
endmodule

// File: rtl/event_timer_sched_chk.sv
module event_timer_sched_chk
  import evsched_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int NUM_EVT = 5,
  parameter int TYPE_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adv_valid,
  input logic [TIME_W-1:0]  adv_amount,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_op,
  input logic [TYPE_W-1:0]  req_type,
  input logic               rsp_valid,
  input logic [TIME_W-1:0]  now_o,
  input logic [NUM_EVT-1:0] fire_o,
  input logic               io_busy_clr,
  input logic               par_irq,
  input logic               par_dma_busy_clr,
  input logic               serial_irq,
  input logic               serial_busy_clr,
  input logic               fatal_o
);
  logic cancel_taken;
  assign cancel_taken = req_valid && req_ready && (req_op == 2'd2);

  // R2
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid |=> now_o == $past(now_o) + $past(adv_amount));
  // R2
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> $stable(now_o));
  // R5
  fire_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_o));
  // R7
  cancel_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_taken |=> rsp_valid);
  // R12
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cancel_taken |=> !rsp_valid);
  // R9
  cancel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_taken |=> ((fire_o >> $past(req_type)) & NUM_EVT'(1)) == '0);
  // R10
  buswr_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o[EVT_BUSWR] |-> (io_busy_clr && !par_irq && !par_dma_busy_clr && !serial_irq && !serial_busy_clr));
  // R10
  pdma_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o[EVT_PDMA] |-> (par_irq && par_dma_busy_clr && !serial_irq && !io_busy_clr));
  // R10
  sdma_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o[EVT_SDMA] |-> (serial_irq && serial_busy_clr && !par_irq && !io_busy_clr));
  // R11
  sent_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o[NUM_EVT-1] |-> fatal_o);
  // R11
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);
endmodule

bind event_timer_sched event_timer_sched_chk #(
  .TIME_W(TIME_W), .NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .adv_valid        (adv_valid),
  .adv_amount       (adv_amount),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_op           (req_op),
  .req_type         (req_type),
  .rsp_valid        (rsp_valid),
  .now_o            (now_o),
  .fire_o           (fire_o),
  .io_busy_clr      (io_busy_clr),
  .par_irq          (par_irq),
  .par_dma_busy_clr (par_dma_busy_clr),
  .serial_irq       (serial_irq),
  .serial_busy_clr  (serial_busy_clr),
  .fatal_o          (fatal_o)
);

// File: tb/event_timer_sched_bench.sv
`timescale 1ns/1ps
module event_timer_sched_bench;
  localparam logic [1:0] ABS = 2'd0, REL = 2'd1, CAN = 2'd2, RSV = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_valid = 1'b0;
  logic [63:0] adv_amount = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_type = '0;
  logic [63:0] req_time = '0;
  logic        rsp_valid;
  logic [63:0] rsp_remain, now_o;
  logic [4:0]  fire_o;
  logic        io_busy_clr, par_irq, par_dma_busy_clr, serial_irq, serial_busy_clr, fatal_o;

  int n_chk = 0, n_fail = 0, nlog = 0, cyc = 0;
  int log_ty [16];
  int log_cy [16];

  always #2 clk = ~clk;

  event_timer_sched u_event_timer_sched (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // firing log, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && fire_o != '0) begin
      int t;
      t = 0;
      for (int i = 0; i < 5; i++) if (fire_o[i]) t = i;
      if (nlog < 16) begin
        log_ty[nlog] = t;
        log_cy[nlog] = cyc;
      end
      nlog++;
      // R10 side-effect strobes match the firing type
      chk({io_busy_clr, par_irq, par_dma_busy_clr, serial_irq, serial_busy_clr} ==
          {fire_o[1], fire_o[2], fire_o[2], fire_o[3], fire_o[3]}, "R10 effects",
          {59'd0, io_busy_clr, par_irq, par_dma_busy_clr, serial_irq, serial_busy_clr},
          {59'd0, fire_o[1], fire_o[2], fire_o[2], fire_o[3], fire_o[3]});
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_req(input logic [1:0] op, input logic [2:0] ty, input logic [63:0] tm);
    req_valid = 1'b1; req_op = op; req_type = ty; req_time = tm;
    step();
    req_valid = 1'b0;
  endtask

  task automatic do_adv(input logic [63:0] a);
    adv_valid = 1'b1; adv_amount = a;
    step();
    adv_valid = 1'b0;
  endtask

  task automatic t_reset();
    idle(3);
    chk(now_o == 0, "R1 now", now_o, 0);
    chk(fire_o == 0 && fatal_o == 0 && rsp_valid == 0, "R1 outputs", {fire_o, fatal_o, rsp_valid}, 0);
    chk(req_ready == 0, "R1 ready in reset", req_ready, 0);
    rst_n = 1'b1;
    idle(2);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_adv();
    do_adv(100);
    chk(now_o == 100, "R2 advance", now_o, 100);
    adv_amount = 55;
    step();
    chk(now_o == 100, "R2 hold", now_o, 100);
  endtask

  task automatic t_abs();
    nlog = 0;
    do_req(ABS, 3'd1, 64'd150);
    do_adv(49);
    idle(3);
    chk(nlog == 0, "R3 early", nlog, 0);
    do_adv(1);
    chk(nlog == 0, "R3 not before next cycle", nlog, 0);
    step();
    chk(nlog == 1 && log_ty[0] == 1, "R3 fire", nlog, 1);
    idle(3);
    chk(nlog == 1, "R3 single pulse", nlog, 1);
  endtask

  task automatic t_rel();
    nlog = 0;
    do_req(REL, 3'd2, 64'd30);
    do_adv(29);
    idle(2);
    chk(nlog == 0, "R4 early", nlog, 0);
    do_adv(1);
    step();
    chk(nlog == 1 && log_ty[0] == 2, "R4 fire", log_ty[0], 2);
  endtask

  task automatic t_order();
    do_req(ABS, 3'd3, 64'd200);
    do_req(ABS, 3'd1, 64'd190);
    do_req(ABS, 3'd2, 64'd200);
    nlog = 0;
    do_adv(50);
    idle(4);
    chk(nlog == 3, "R5 count", nlog, 3);
    chk(log_ty[0] == 1 && log_ty[1] == 2 && log_ty[2] == 3, "R5 order",
        log_ty[0] * 100 + log_ty[1] * 10 + log_ty[2], 123);
    chk(log_cy[1] == log_cy[0] + 1 && log_cy[2] == log_cy[1] + 1, "R5 successive",
        log_cy[2] - log_cy[0], 2);
  endtask

  task automatic t_over();
    do_req(ABS, 3'd1, 64'd240);
    do_req(ABS, 3'd1, 64'd260);
    nlog = 0;
    do_adv(15);
    idle(3);
    chk(nlog == 0, "R6 old time dropped", nlog, 0);
    do_adv(15);
    idle(3);
    chk(nlog == 1 && log_ty[0] == 1, "R6 new time", nlog, 1);
  endtask

  task automatic t_cancel();
    do_req(REL, 3'd3, 64'd500);
    do_adv(100);
    do_req(CAN, 3'd3, 64'd0);
    chk(rsp_valid == 1 && rsp_remain == 400, "R7 remaining", rsp_remain, 400);
    nlog = 0;
    do_adv(1000);
    idle(3);
    chk(nlog == 0, "R7 removed", nlog, 0);
    do_req(ABS, 3'd2, 64'd1400);
    adv_valid = 1'b1; adv_amount = 10;
    req_valid = 1'b1; req_op = CAN; req_type = 3'd2;
    step();
    adv_valid = 1'b0; req_valid = 1'b0;
    chk(rsp_valid == 1 && rsp_remain == 40, "R7 uses pre-advance count", rsp_remain, 40);
    chk(now_o == 1370, "R7 advance same cycle", now_o, 1370);
  endtask

  task automatic t_miss();
    do_req(CAN, 3'd1, 64'd0);
    chk(rsp_valid == 1 && rsp_remain == 0, "R8 nothing pending", rsp_remain, 0);
    do_req(CAN, 3'd0, 64'd0);
    chk(rsp_valid == 1 && rsp_remain == 0, "R8 type none", rsp_remain, 0);
  endtask

  task automatic t_race();
    do_req(ABS, 3'd1, 64'd1375);
    nlog = 0;
    do_adv(5);
    do_req(CAN, 3'd1, 64'd0);
    chk(rsp_valid == 1 && rsp_remain == 0, "R9 cancel at due edge", rsp_remain, 0);
    idle(3);
    chk(nlog == 0, "R9 no pulse", nlog, 0);
  endtask

  task automatic t_ignored();
    nlog = 0;
    do_req(ABS, 3'd0, 64'd1376);
    do_req(RSV, 3'd2, 64'd1376);
    chk(rsp_valid == 0, "R12 reserved op no response", rsp_valid, 0);
    do_req(ABS, 3'd5, 64'd1376);
    do_adv(10);
    idle(3);
    chk(nlog == 0, "R12 no firing", nlog, 0);
  endtask

  task automatic t_sentinel();
    chk(fatal_o == 0, "R11 fatal idle", fatal_o, 0);
    do_req(CAN, 3'd4, 64'd0);
    chk(rsp_remain == 64'hFFFF_FFFF_FFFF_FFFF - 64'd1385, "R11 preload",
        rsp_remain, 64'hFFFF_FFFF_FFFF_FFFF - 64'd1385);
    nlog = 0;
    do_req(ABS, 3'd4, 64'd1387);
    do_adv(2);
    step();
    chk(nlog == 1 && log_ty[0] == 4, "R11 sentinel fire", log_ty[0], 4);
    chk(fatal_o == 1, "R11 fatal raised", fatal_o, 1);
    idle(3);
    chk(fatal_o == 1, "R11 fatal sticky", fatal_o, 1);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_adv();
    t_abs();
    t_rel();
    t_order();
    t_over();
    t_cancel();
    t_miss();
    t_race();
    t_ignored();
    t_sentinel();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule